// File: doc/BRIEF.md
# Load/Use Hazard Interlock with Stage Registers

This block keeps a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) correct when an instruction needs a register that the instruction just ahead of it is still loading from memory. It holds the stage registers that carry each instruction's descriptor: instruction code, two source register IDs and two destination register IDs. It looks at the decode and execute registers and drives a hold and an insert-no-op control for every stage. Every other dependency is left to the forwarding paths, which are not part of this block. Only the load/use case remains, because a loaded value exists only at the end of the memory stage.

When the instruction in execute is a load or a pop, and its memory destination register is one of the decode instruction's sources, the block freezes the fetch and decode registers for one cycle. In that same cycle it loads a no-op into the execute register. The memory and write-back registers keep flowing. One cycle later the loaded value can be forwarded from the memory stage, so the held instruction moves on. Register ID 8 is the "no register" code and never starts a hold.

Each stage register has three modes: it loads its input, it holds its contents, or it loads the no-op descriptor. Reset fills every register with the no-op state.

Top module: `hzd_pipe_ctrl`

## Requirements
- R1: A hazard (`load_use`=1) exists exactly when the execute descriptor's code is 5 (load) or 11 (pop) and its memory destination ID equals the decode descriptor's first or second source ID.
- R2: A memory destination ID of 8 means "no register" and never causes a hazard, even when a decode source ID is also 8.
- R3: During a hazard, `stage_stall` is 5'b00011 and `stage_bubble` is 5'b00100 (bit 0 fetch, 1 decode, 2 execute, 3 memory, 4 write-back).
- R4: With no hazard, both control vectors are zero and at the next edge `pc_f` takes `fet_pc`, `desc_d` takes `fet_desc`, `desc_e` takes `desc_d`, `desc_m` takes `desc_e` and `desc_w` takes `desc_m`. The descriptor layout is [19:16] code, [15:12] source A, [11:8] source B, [7:4] ALU destination, [3:0] memory destination.
- R5: A stage with its hold control set keeps its contents across the edge and ignores its input.
- R6: A stage with its insert control set loads the no-op descriptor 20'h18888 (code 1, all four register IDs 8).
- R7: A hazard lasts exactly one cycle. In the next cycle the held instruction advances into execute.
- R8: No stage ever has its hold and insert controls set together.
- R9: While `rst_n` is low, every descriptor register holds 20'h18888 and `pc_f` is 0.
- R10: An instruction in execute whose code is neither 5 nor 11 causes no hazard, whatever its register IDs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| fet_pc | input | 8 | Next program counter offered to the fetch register |
| fet_desc | input | 20 | Descriptor of the instruction just fetched, offered to the decode register |
| pc_f | output | 8 | Fetch register contents |
| desc_d | output | 20 | Decode register descriptor |
| desc_e | output | 20 | Execute register descriptor |
| desc_m | output | 20 | Memory register descriptor |
| desc_w | output | 20 | Write-back register descriptor |
| stage_stall | output | 5 | Per-stage hold controls |
| stage_bubble | output | 5 | Per-stage insert-no-op controls |
| load_use | output | 1 | Load/use hazard detected this cycle |

## Verification
The controls and `load_use` are combinational on the decode and execute registers, so they are due in the same cycle as the register contents that cause them. Register contents are due one edge after the inputs and controls that form them. The bench keeps its own five-stage model, compares both groups at the falling edge before it drives new inputs, and then steps the model once per rising edge. A generated program runs through the pipeline: directed load/pop pairs, a producer with ID 8, a producer that is not a load, and an arithmetic mix of codes and IDs. Every adjacent pair is therefore checked against the hazard rule.

// File: rtl/hzd_pkg.sv
// Shared widths, codes and descriptor type of the hazard interlock.
// Assumes 4-bit instruction codes and 4-bit register IDs with ID 8 as "none".
package hzd_pkg;
    localparam int IC_W     = 4;
    localparam int ID_W     = 4;
    localparam int N_STAGES = 5;

    localparam logic [ID_W-1:0] ID_NONE = ID_W'(8);
    localparam logic [IC_W-1:0] IC_NOP  = IC_W'(1);
    localparam logic [IC_W-1:0] IC_LOAD = IC_W'(5);
    localparam logic [IC_W-1:0] IC_POP  = IC_W'(11);

    typedef struct packed {
        logic [IC_W-1:0] icode;
        logic [ID_W-1:0] src_a;
        logic [ID_W-1:0] src_b;
        logic [ID_W-1:0] dst_e;
        logic [ID_W-1:0] dst_m;
    } desc_t;

    localparam int DESC_W = $bits(desc_t);

    localparam desc_t DESC_NOP = '{icode: IC_NOP, src_a: ID_NONE, src_b: ID_NONE,
                                   dst_e: ID_NONE, dst_m: ID_NONE};

    // Action each stage takes while a load/use hazard is present.
    typedef enum logic [1:0] { ACT_PASS, ACT_HOLD, ACT_INSERT } stage_act_e;

    // Stage index: 0 fetch, 1 decode, 2 execute, 3 memory, 4 write-back.
    function automatic stage_act_e hazard_action(input int stage);
        case (stage)
            0, 1:    return ACT_HOLD;
            2:       return ACT_INSERT;
            default: return ACT_PASS;
        endcase
    endfunction
endpackage

// File: rtl/hzd_loaduse_det.sv
// Flags a load/use dependency between the decode and execute instructions.
// Assumes the execute-stage memory destination is only meaningful for loads and pops.
module hzd_loaduse_det
    import hzd_pkg::*;
(
    input  logic [ID_W-1:0] dec_src_a,
    input  logic [ID_W-1:0] dec_src_b,
    input  logic [IC_W-1:0] ex_icode,
    input  logic [ID_W-1:0] ex_dst_m,
    output logic            hazard
);
    logic is_mem_read;
    logic dst_real;
    logic hit_a;
    logic hit_b;

    // Classify the execute instruction and compare its load target with both sources.
    always_comb begin
        is_mem_read = (ex_icode == IC_LOAD) || (ex_icode == IC_POP);
        dst_real    = (ex_dst_m != ID_NONE);
        hit_a       = (ex_dst_m == dec_src_a);
        hit_b       = (ex_dst_m == dec_src_b);
        hazard      = is_mem_read && dst_real && (hit_a || hit_b);
    end
endmodule

// File: rtl/hzd_stage_ctrl.sv
// Expands the hazard flag into per-stage hold and insert controls.
// Assumes the per-stage action table in hzd_pkg; stages never both hold and insert.
module hzd_stage_ctrl
    import hzd_pkg::*;
#(
    parameter int STAGES = N_STAGES
) (
    input  logic              hazard,
    output logic [STAGES-1:0] stall,
    output logic [STAGES-1:0] bubble
);
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        localparam stage_act_e ACT = hazard_action(s);
        // Drive this stage's controls from its hazard action.
        always_comb begin
            stall[s]  = hazard && (ACT == ACT_HOLD);
            bubble[s] = hazard && (ACT == ACT_INSERT);
        end
    end
endmodule

// File: rtl/hzd_pipe_reg.sv
// Pipeline register with load, hold and insert-no-op modes.
// Assumes stall and bubble are not raised together; bubble wins if they are.
module hzd_pipe_reg #(
    parameter int             W       = 8,
    parameter logic [W-1:0]   NOP_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stall,
    input  logic         bubble,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Update contents by mode: reset/insert no-op, hold, or load.
    always_ff @(posedge clk) begin
        if (!rst_n || bubble) begin
            q <= NOP_VAL;
        end else if (!stall) begin
            q <= d;
        end
    end
endmodule

// File: rtl/hzd_pipe_ctrl.sv
// Top: five stage registers plus load/use interlock control.
// Assumes forwarding elsewhere resolves every other dependency; index 0 is fetch.
module hzd_pipe_ctrl
    import hzd_pkg::*;
#(
    parameter int PC_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [PC_W-1:0]     fet_pc,
    input  logic [DESC_W-1:0]   fet_desc,
    output logic [PC_W-1:0]     pc_f,
    output logic [DESC_W-1:0]   desc_d,
    output logic [DESC_W-1:0]   desc_e,
    output logic [DESC_W-1:0]   desc_m,
    output logic [DESC_W-1:0]   desc_w,
    output logic [N_STAGES-1:0] stage_stall,
    output logic [N_STAGES-1:0] stage_bubble,
    output logic                load_use
);
    localparam int N_DESC = N_STAGES - 1;

    desc_t stage_d [1:N_DESC];
    desc_t stage_q [1:N_DESC];

    // Fetch register holds the program counter.
    hzd_pipe_reg #(.W(PC_W), .NOP_VAL('0)) u_freg (
        .clk    (clk),
        .rst_n  (rst_n),
        .stall  (stage_stall[0]),
        .bubble (stage_bubble[0]),
        .d      (fet_pc),
        .q      (pc_f)
    );

    // Descriptor registers, decode through write-back, chained.
    for (genvar s = 1; s <= N_DESC; s++) begin : g_desc
        if (s == 1) begin : g_first
            assign stage_d[s] = desc_t'(fet_desc);
        end else begin : g_next
            assign stage_d[s] = stage_q[s-1];
        end
        hzd_pipe_reg #(.W(DESC_W), .NOP_VAL(DESC_NOP)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .stall  (stage_stall[s]),
            .bubble (stage_bubble[s]),
            .d      (stage_d[s]),
            .q      (stage_q[s])
        );
    end

    hzd_loaduse_det u_det (
        .dec_src_a (stage_q[1].src_a),
        .dec_src_b (stage_q[1].src_b),
        .ex_icode  (stage_q[2].icode),
        .ex_dst_m  (stage_q[2].dst_m),
        .hazard    (load_use)
    );

    hzd_stage_ctrl #(.STAGES(N_STAGES)) u_ctrl (
        .hazard (load_use),
        .stall  (stage_stall),
        .bubble (stage_bubble)
    );

    assign desc_d = stage_q[1];
    assign desc_e = stage_q[2];
    assign desc_m = stage_q[3];
    assign desc_w = stage_q[4];
endmodule

// File: rtl/hzd_pipe_ctrl_chk.sv
// Checker bound to hzd_pipe_ctrl: temporal rules of the interlock.
// Assumes the default 20-bit descriptor layout and five stages.
module hzd_pipe_ctrl_chk
    import hzd_pkg::*;
#(
    parameter int PC_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [PC_W-1:0]     fet_pc,
    input logic [PC_W-1:0]     pc_f,
    input logic [DESC_W-1:0]   fet_desc,
    input logic [DESC_W-1:0]   desc_d,
    input logic [DESC_W-1:0]   desc_e,
    input logic [DESC_W-1:0]   desc_m,
    input logic [DESC_W-1:0]   desc_w,
    input logic [N_STAGES-1:0] stage_stall,
    input logic [N_STAGES-1:0] stage_bubble,
    input logic                load_use
);
    p_hazard_ctrl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_use |-> (stage_stall == 5'b00011) && (stage_bubble == 5'b00100));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stage_stall[1] |=> $stable(desc_d) && $stable(pc_f));

    p_insert_nop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stage_bubble[2] |=> (desc_e == DESC_NOP));

    p_flow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_use |=> (desc_e == $past(desc_d)) && (desc_w == $past(desc_m)));

    p_single_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_use |=> !load_use);

    p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_stall & stage_bubble) == '0);

    p_reset_r9: assert property (@(posedge clk)
        !rst_n |=> (desc_d == DESC_NOP) && (desc_w == DESC_NOP) && (pc_f == '0));
endmodule

bind hzd_pipe_ctrl hzd_pipe_ctrl_chk #(.PC_W(PC_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fet_pc       (fet_pc),
    .pc_f         (pc_f),
    .fet_desc     (fet_desc),
    .desc_d       (desc_d),
    .desc_e       (desc_e),
    .desc_m       (desc_m),
    .desc_w       (desc_w),
    .stage_stall  (stage_stall),
    .stage_bubble (stage_bubble),
    .load_use     (load_use)
);

// File: tb/hzd_pipe_ctrl_tb.sv
// Bench: runs a generated program through the pipeline against a bench-side stage model.
module hzd_pipe_ctrl_tb;
    localparam logic [19:0] NOP = 20'h18888;
    localparam int NCYC = 700;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  fet_pc = '0;
    logic [19:0] fet_desc = NOP;
    logic [7:0]  pc_f;
    logic [19:0] desc_d, desc_e, desc_m, desc_w;
    logic [4:0]  stage_stall, stage_bubble;
    logic        load_use;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    hzd_pipe_ctrl u_dut (
        .clk (clk), .rst_n (rst_n), .fet_pc (fet_pc), .fet_desc (fet_desc),
        .pc_f (pc_f), .desc_d (desc_d), .desc_e (desc_e), .desc_m (desc_m),
        .desc_w (desc_w), .stage_stall (stage_stall), .stage_bubble (stage_bubble),
        .load_use (load_use)
    );

    function automatic logic [19:0] mk(input int ic, input int sa, input int sb,
                                       input int de, input int dm);
        return {4'(ic), 4'(sa), 4'(sb), 4'(de), 4'(dm)};
    endfunction

    // Program memory: directed pairs first, then an arithmetic mix.
    function automatic logic [19:0] prog(input logic [7:0] pc);
        int i = int'(pc);
        int ic;
        case (i)
            0: return mk(5, 8, 8, 8, 3);   // load r3
            1: return mk(2, 3, 7, 2, 8);   // uses r3 -> hazard
            2: return mk(11, 8, 8, 8, 4);  // pop r4
            3: return mk(2, 6, 4, 1, 8);   // uses r4 via B -> hazard
            4: return mk(5, 8, 8, 8, 8);   // load to none
            5: return mk(2, 8, 8, 0, 8);   // sources none -> no hazard
            6: return mk(3, 8, 8, 8, 6);   // non-load with dst_m 6
            7: return mk(2, 6, 6, 0, 8);   // match but not a load
            default: begin
                case ((i * 7) % 4)
                    0: ic = 5;
                    1: ic = 11;
                    2: ic = i % 16;
                    default: ic = (i * 3) % 16;
                endcase
                return mk(ic, (i * 5) % 9, (i * 11 + 3) % 9, (i * 13) % 9, (i * 3 + 1) % 9);
            end
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0]  m_pc;
        logic [19:0] m_d, m_e, m_m, m_w;
        bit          prev_hz, hz, isld;
        string       tg;

        // R9: reset state
        repeat (3) @(negedge clk);
        chk(pc_f == 8'h00, "R9 pc", 32'(pc_f), 32'h0);
        chk(desc_d == NOP, "R9 desc_d", 32'(desc_d), 32'(NOP));
        chk(desc_e == NOP, "R9 desc_e", 32'(desc_e), 32'(NOP));
        chk(desc_m == NOP, "R9 desc_m", 32'(desc_m), 32'(NOP));
        chk(desc_w == NOP, "R9 desc_w", 32'(desc_w), 32'(NOP));
        rst_n = 1'b1;

        m_pc = '0; m_d = NOP; m_e = NOP; m_m = NOP; m_w = NOP;
        prev_hz = 1'b0;
        for (int c = 0; c < NCYC; c++) begin
            @(negedge clk);
            // register contents formed by the previous edge
            chk(pc_f == m_pc, prev_hz ? "R5 pc" : "R4 pc", 32'(pc_f), 32'(m_pc));
            chk(desc_d == m_d, prev_hz ? "R5 desc_d" : "R4 desc_d", 32'(desc_d), 32'(m_d));
            chk(desc_e == m_e, prev_hz ? "R6 desc_e" : "R4 desc_e", 32'(desc_e), 32'(m_e));
            chk(desc_m == m_m, "R4 desc_m", 32'(desc_m), 32'(m_m));
            chk(desc_w == m_w, "R4 desc_w", 32'(desc_w), 32'(m_w));
            // controls due in the same cycle
            isld = (m_e[19:16] == 4'd5) || (m_e[19:16] == 4'd11);
            hz = isld && (m_e[3:0] != 4'd8) &&
                 ((m_e[3:0] == m_d[15:12]) || (m_e[3:0] == m_d[11:8]));
            if (hz)                                        tg = "R1";
            else if (prev_hz)                              tg = "R7";
            else if (isld && m_e[3:0] == 4'd8)             tg = "R2";
            else if (!isld)                                tg = "R10";
            else                                           tg = "R4";
            chk(load_use == hz, {tg, " load_use"}, 32'(load_use), 32'(hz));
            chk(stage_stall == (hz ? 5'b00011 : 5'b0), hz ? "R3 stall" : {tg, " stall"},
                32'(stage_stall), hz ? 32'h3 : 32'h0);
            chk(stage_bubble == (hz ? 5'b00100 : 5'b0), hz ? "R3 bubble" : {tg, " bubble"},
                32'(stage_bubble), hz ? 32'h4 : 32'h0);
            chk((stage_stall & stage_bubble) == 5'b0, "R8 exclusive",
                32'(stage_stall & stage_bubble), 32'h0);
            // drive the fetch side from the model PC
            fet_pc   = m_pc + 8'd1;
            fet_desc = prog(m_pc);
            // step the model across the coming edge
            m_w = m_m;
            m_m = m_e;
            if (hz) begin
                m_e = NOP;
            end else begin
                m_e  = m_d;
                m_d  = fet_desc;
                m_pc = fet_pc;
            end
            prev_hz = hz;
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule